// File: doc/BRIEF.md
# Synchronous Serial Transmit Path with Holding Buffer and Queue

This block drives the outgoing half of a clocked synchronous serial link. A CPU write port feeds a word path of up to three stages: an optional small queue, a one-word holding buffer and a shift register that puts the word on the serial data line, least significant bit first. The serial clock comes from one of two sources. The block can generate it internally as a fixed division of the system clock, and then stops it as soon as no further word is waiting. It can also take it from the link partner, and then it must keep up with the partner's clock.

Three mode inputs choose the arrangement. The first picks holding-buffer (double-buffered) operation or direct loading of the shifter. The second places the queue in front of the holding buffer. The third picks the serial clock source. The block reports a one-cycle transmit interrupt and a holding-buffer-empty level. It keeps two sticky error bits: one for an underrun under an external clock, and one for a word dropped at a full queue. Both error bits clear when software strobes the status read input.

Top module: `sio_tx_path`

## Requirements
- R1: After reset, sdo and sclk_out are 1, hold_empty is 1, and tx_irq, underrun_err and fifo_ovf are 0.
- R2: With dbuf_en=1 and fifo_en=0, a write fills the holding buffer, so hold_empty reads 0 on the next cycle. When the word moves into the shifter, hold_empty returns to 1 and tx_irq is high for exactly one cycle.
- R3: A frame is 8 bits sent LSB first. sdo changes only when the serial clock falls, and sdo sits at 1 while no frame is in flight.
- R4: With int_clk=1, sclk_out runs at the system clock divided by 4, low for 2 cycles and then high for 2. It starts when a word is loaded. Back-to-back words keep the 4-cycle period with no gap between frames. sclk_out returns high and stays there once no word remains.
- R5: With int_clk=0, ext_sclk passes through a two-stage synchronizer. Each falling edge of ext_sclk advances the shifter. An idle shifter holding a buffered word starts the frame on a falling edge, which puts bit 0 on sdo.
- R6: With int_clk=0, dbuf_en=1 and fifo_en=0, suppose the falling edge that ends bit 7 finds the holding buffer empty. Then underrun_err is set, and it stays set across later edges.
- R7: underrun_err is never set while int_clk=1, and it is not set in queue mode.
- R8: A one-cycle stat_rd pulse clears both underrun_err and fifo_ovf on the next cycle.
- R9: With dbuf_en=1 and fifo_en=1, writes enter the queue, and the queue head moves into an empty holding buffer on the next cycle. At a transfer into the shifter, the holding buffer refills from the queue on the same edge. While words remain, hold_empty stays 0, and tx_irq pulses only when the holding buffer is left empty.
- R10: The queue holds 4 words. A write to a full queue is discarded and sets fifo_ovf. The discarded word is never transmitted.
- R11: With dbuf_en=0, a write loads the shifter only while no word is pending or in flight, and any other write is ignored. tx_irq pulses once at the end of each frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | CPU write strobe |
| wr_data | input | 8 | CPU write data |
| dbuf_en | input | 1 | 1: holding buffer in use; 0: writes load the shifter |
| fifo_en | input | 1 | 1: queue placed before the holding buffer |
| int_clk | input | 1 | 1: serial clock generated internally; 0: taken from ext_sclk |
| stat_rd | input | 1 | Status read strobe; clears the error bits |
| ext_sclk | input | 1 | Serial clock from the link partner |
| sdo | output | 1 | Serial data out |
| sclk_out | output | 1 | Generated serial clock, idles high |
| tx_irq | output | 1 | One-cycle transmit interrupt |
| hold_empty | output | 1 | Holding buffer empty |
| underrun_err | output | 1 | Sticky underrun flag |
| fifo_ovf | output | 1 | Sticky queue overflow flag |

## Verification
The bench builds the block with its defaults: 8-bit words, a 4-entry queue and a divide-by-4 internal clock. With a queue that shallow, six back-to-back writes fill the holding buffer, fill the queue and then drop a word, so the overflow and refill corners take only a few cycles to reach. A divide-by-4 clock keeps each internal frame to 32 cycles. That leaves room for back-to-back, starved and direct-load runs, and for every external-clock ordering: prefill, mid-frame refill, underrun and queue drain.

// File: rtl/sio_tx_pkg.sv
package sio_tx_pkg;
  localparam int unsigned SIO_DATA_W     = 8;
  localparam int unsigned SIO_FIFO_DEPTH = 4;
  localparam int unsigned SIO_CLK_DIV    = 4;

  typedef struct packed {
    logic underrun;
    logic overflow;
  } sio_err_t;
endpackage

// File: rtl/sio_tx_fifo.sv
module sio_tx_fifo #(
  parameter int unsigned W     = 8,
  parameter int unsigned DEPTH = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         push_i,
  input  logic         pop_i,
  input  logic [W-1:0] din_i,
  output logic [W-1:0] dout_o,
  output logic         empty_o,
  output logic         drop_o
);
  localparam int unsigned AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int unsigned CW = $clog2(DEPTH + 1);

  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wr_ptr_q, wr_ptr_d, rd_ptr_q, rd_ptr_d;
  logic [CW-1:0] count_q, count_d;
  logic          full, wr_ok, rd_ok;

  function automatic logic [AW-1:0] ptr_inc(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  assign full    = (count_q == CW'(DEPTH));
  assign empty_o = (count_q == '0);
  assign wr_ok   = push_i & ~full;
  assign rd_ok   = pop_i & ~empty_o;
  assign drop_o  = push_i & full;
  assign dout_o  = mem[rd_ptr_q];

  for (genvar g = 0; g < DEPTH; g++) begin : g_slot
    always_ff @(posedge clk) begin
      if (wr_ok && (wr_ptr_q == AW'(g))) mem[g] <= din_i;
    end
  end

  always_comb begin
    wr_ptr_d = wr_ok ? ptr_inc(wr_ptr_q) : wr_ptr_q;
    rd_ptr_d = rd_ok ? ptr_inc(rd_ptr_q) : rd_ptr_q;
    count_d  = count_q;
    case ({wr_ok, rd_ok})
      2'b10:   count_d = count_q + 1'b1;
      2'b01:   count_d = count_q - 1'b1;
      default: count_d = count_q;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr_q <= '0;
      rd_ptr_q <= '0;
      count_q  <= '0;
    end else begin
      wr_ptr_q <= wr_ptr_d;
      rd_ptr_q <= rd_ptr_d;
      count_q  <= count_d;
    end
  end

  // R10
  no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (push_i && full && !pop_i) |=> (count_q == CW'(DEPTH)));
endmodule

// File: rtl/sio_tx_clkgen.sv
module sio_tx_clkgen #(
  parameter int unsigned DIV = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic int_mode_i,
  input  logic ext_sclk_i,
  input  logic busy_i,
  output logic tick_o,
  output logic sclk_o
);
  localparam int unsigned DW   = (DIV > 1) ? $clog2(DIV) : 1;
  localparam int unsigned HALF = DIV / 2;

  logic [DW-1:0] div_q, div_d;
  logic [2:0]    ext_q, ext_d;
  logic          run, int_tick, ext_tick;

  assign run      = int_mode_i & busy_i;
  assign int_tick = run & (div_q == DW'(DIV - 1));
  assign ext_tick = ~int_mode_i & ext_q[2] & ~ext_q[1];
  assign tick_o   = int_tick | ext_tick;
  assign sclk_o   = ~(run & (div_q < DW'(HALF)));

  always_comb begin
    div_d = '0;
    if (run) div_d = int_tick ? '0 : div_q + 1'b1;
    ext_d = {ext_q[1], ext_q[0], ext_sclk_i};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      div_q <= '0;
      ext_q <= '1;
    end else begin
      div_q <= div_d;
      ext_q <= ext_d;
    end
  end

  // R4
  clk_low_after_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (int_tick && busy_i && int_mode_i) |=> (div_q == '0));
endmodule

// File: rtl/sio_tx_shifter.sv
module sio_tx_shifter #(
  parameter int unsigned W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         tick_i,
  input  logic         load_i,
  input  logic [W-1:0] data_i,
  output logic         busy_o,
  output logic         sdo_o,
  output logic         frame_end_o
);
  localparam int unsigned CW = (W > 1) ? $clog2(W) : 1;

  logic [W-1:0]  sreg_q, sreg_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic          busy_q, busy_d;

  assign frame_end_o = busy_q & tick_i & (cnt_q == CW'(W - 1));
  assign busy_o      = busy_q;
  assign sdo_o       = busy_q ? sreg_q[0] : 1'b1;

  always_comb begin
    sreg_d = sreg_q;
    cnt_d  = cnt_q;
    busy_d = busy_q;
    if (load_i) begin
      sreg_d = data_i;
      cnt_d  = '0;
      busy_d = 1'b1;
    end else if (frame_end_o) begin
      busy_d = 1'b0;
    end else if (busy_q && tick_i) begin
      sreg_d = {1'b1, sreg_q[W-1:1]};
      cnt_d  = cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sreg_q <= '1;
      cnt_q  <= '0;
      busy_q <= 1'b0;
    end else begin
      sreg_q <= sreg_d;
      cnt_q  <= cnt_d;
      busy_q <= busy_d;
    end
  end

  // R3
  mid_frame_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && tick_i && (cnt_q != CW'(W - 1))) |=> busy_q);
endmodule

// File: rtl/sio_tx_path.sv
module sio_tx_path
  import sio_tx_pkg::*;
#(
  parameter int unsigned DATA_W     = SIO_DATA_W,
  parameter int unsigned FIFO_DEPTH = SIO_FIFO_DEPTH,
  parameter int unsigned CLK_DIV    = SIO_CLK_DIV
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              dbuf_en,
  input  logic              fifo_en,
  input  logic              int_clk,
  input  logic              stat_rd,
  input  logic              ext_sclk,
  output logic              sdo,
  output logic              sclk_out,
  output logic              tx_irq,
  output logic              hold_empty,
  output logic              underrun_err,
  output logic              fifo_ovf
);
  logic [1:0] rst_pipe_q;
  logic       rst_n_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe_q <= '0;
    else        rst_pipe_q <= {rst_pipe_q[0], 1'b1};
  end
  assign rst_n_q = rst_pipe_q[1];

  logic              tick, busy, frame_end, load;
  logic              q_mode, fifo_push, fifo_pop, fifo_empty, fifo_drop;
  logic [DATA_W-1:0] fifo_head;
  logic [DATA_W-1:0] hold_q, hold_d;
  logic              hold_full_q, hold_full_d;
  logic              wr_hold, irq_q, irq_d, under_set;
  sio_err_t          err_q, err_d;

  assign q_mode    = dbuf_en & fifo_en;
  assign fifo_push = wr_en & q_mode;
  assign load      = hold_full_q & (frame_end | (~busy & (int_clk | tick)));
  assign fifo_pop  = q_mode & ~fifo_empty & (load | ~hold_full_q);
  assign wr_hold   = wr_en & (dbuf_en ? ~fifo_en : (~hold_full_q & ~busy));
  assign under_set = ~int_clk & dbuf_en & ~fifo_en & frame_end & ~hold_full_q;

  sio_tx_fifo #(.W(DATA_W), .DEPTH(FIFO_DEPTH)) u_fifo (
    .clk    (clk),
    .rst_n  (rst_n_q),
    .push_i (fifo_push),
    .pop_i  (fifo_pop),
    .din_i  (wr_data),
    .dout_o (fifo_head),
    .empty_o(fifo_empty),
    .drop_o (fifo_drop)
  );

  sio_tx_clkgen #(.DIV(CLK_DIV)) u_clkgen (
    .clk       (clk),
    .rst_n     (rst_n_q),
    .int_mode_i(int_clk),
    .ext_sclk_i(ext_sclk),
    .busy_i    (busy),
    .tick_o    (tick),
    .sclk_o    (sclk_out)
  );

  sio_tx_shifter #(.W(DATA_W)) u_shift (
    .clk        (clk),
    .rst_n      (rst_n_q),
    .tick_i     (tick),
    .load_i     (load),
    .data_i     (hold_q),
    .busy_o     (busy),
    .sdo_o      (sdo),
    .frame_end_o(frame_end)
  );

  always_comb begin
    hold_d      = hold_q;
    hold_full_d = hold_full_q;
    if (wr_hold) begin
      hold_d      = wr_data;
      hold_full_d = 1'b1;
    end else if (fifo_pop) begin
      hold_d      = fifo_head;
      hold_full_d = 1'b1;
    end else if (load) begin
      hold_full_d = 1'b0;
    end
    irq_d = dbuf_en ? (hold_full_q & ~hold_full_d) : frame_end;
    err_d.underrun = under_set | (err_q.underrun & ~stat_rd);
    err_d.overflow = fifo_drop | (err_q.overflow & ~stat_rd);
  end

  always_ff @(posedge clk or negedge rst_n_q) begin
    if (!rst_n_q) begin
      hold_q      <= '0;
      hold_full_q <= 1'b0;
      irq_q       <= 1'b0;
      err_q       <= '0;
    end else begin
      hold_q      <= hold_d;
      hold_full_q <= hold_full_d;
      irq_q       <= irq_d;
      err_q       <= err_d;
    end
  end

  assign tx_irq       = irq_q;
  assign hold_empty   = ~hold_full_q;
  assign underrun_err = err_q.underrun;
  assign fifo_ovf     = err_q.overflow;

  // R2
  xfer_irq_chk: assert property (@(posedge clk) disable iff (!rst_n_q)
    (dbuf_en && !fifo_en && load && !wr_en) |=> (hold_empty && tx_irq));

  // R9
  refill_chk: assert property (@(posedge clk) disable iff (!rst_n_q)
    (q_mode && !hold_full_q && !fifo_empty) |=> !hold_empty);

  // R7
  no_int_underrun_chk: assert property (@(posedge clk) disable iff (!rst_n_q)
    (int_clk && !underrun_err) |=> !underrun_err);

  // R8
  stat_clr_chk: assert property (@(posedge clk) disable iff (!rst_n_q)
    (stat_rd && !frame_end && !fifo_drop) |=> (!underrun_err && !fifo_ovf));
endmodule

// File: tb/sim_sio_tx_path.sv
module sim_sio_tx_path;
  localparam int CLK_PERIOD = 10;
  localparam int EH = 6;

  logic       clk = 1'b0;
  logic       rst_n, wr_en, dbuf_en, fifo_en, int_clk, stat_rd, ext_sclk;
  logic [7:0] wr_data;
  logic       sdo, sclk_out, tx_irq, hold_empty, underrun_err, fifo_ovf;

  int n_chk = 0;
  int n_fail = 0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  sio_tx_path u0 (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
    .dbuf_en(dbuf_en), .fifo_en(fifo_en), .int_clk(int_clk),
    .stat_rd(stat_rd), .ext_sclk(ext_sclk), .sdo(sdo), .sclk_out(sclk_out),
    .tx_irq(tx_irq), .hold_empty(hold_empty), .underrun_err(underrun_err),
    .fifo_ovf(fifo_ovf)
  );

  // monitor: rising edges of the generated clock and interrupt pulses
  int   cyc = 0;
  int   cap_n = 0;
  int   irq_n = 0;
  logic cap_bit [256];
  int   cap_t [256];
  logic prev_sclk = 1'b1;

  always @(negedge clk) begin
    cyc = cyc + 1;
    if (!prev_sclk && sclk_out && cap_n < 256) begin
      cap_bit[cap_n] = sdo;
      cap_t[cap_n]   = cyc;
      cap_n = cap_n + 1;
    end
    prev_sclk = sclk_out;
    if (tx_irq) irq_n = irq_n + 1;
  end

  function automatic logic [7:0] cap_byte(input int base);
    logic [7:0] b;
    for (int i = 0; i < 8; i++) b[i] = cap_bit[base + i];
    return b;
  endfunction

  task automatic check(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: got %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic do_reset(input logic db, input logic fe, input logic ic);
    @(negedge clk);
    rst_n = 1'b0; wr_en = 1'b0; wr_data = '0; stat_rd = 1'b0; ext_sclk = 1'b1;
    dbuf_en = db; fifo_en = fe; int_clk = ic;
    idle(2);
    rst_n = 1'b1;
    idle(4);
  endtask

  task automatic wr(input logic [7:0] d);
    wr_en = 1'b1; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd_status();
    stat_rd = 1'b1;
    @(negedge clk);
    stat_rd = 1'b0;
    @(negedge clk);
  endtask

  task automatic ext_bit(output logic b);
    ext_sclk = 1'b0;
    idle(EH);
    b = sdo;
    ext_sclk = 1'b1;
    idle(EH);
  endtask

  task automatic ext_byte(output logic [7:0] v);
    logic b;
    for (int i = 0; i < 8; i++) begin
      ext_bit(b);
      v[i] = b;
    end
  endtask

  task automatic t_reset();
    do_reset(1'b1, 1'b0, 1'b1);
    check("R1", "sdo", sdo, 1);
    check("R1", "sclk_out", sclk_out, 1);
    check("R1", "hold_empty", hold_empty, 1);
    check("R1", "tx_irq", tx_irq, 0);
    check("R1", "underrun_err", underrun_err, 0);
    check("R1", "fifo_ovf", fifo_ovf, 0);
  endtask

  task automatic t_dbuf_ext();
    logic [7:0] v;
    logic b;
    int irq0;
    do_reset(1'b1, 1'b0, 1'b0);
    irq0 = irq_n;
    wr(8'hA5);
    idle(3);
    check("R2", "hold filled", hold_empty, 0);
    check("R2", "no irq before transfer", irq_n - irq0, 0);
    ext_byte(v);
    check("R5", "external byte LSB first", v, 8'hA5);
    check("R2", "irq pulses once on transfer", irq_n - irq0, 1);
    check("R2", "hold empty after transfer", hold_empty, 1);
    check("R6", "no underrun mid frame", underrun_err, 0);
    ext_bit(b);
    check("R3", "sdo idles high", b, 1);
    check("R6", "underrun on starved frame end", underrun_err, 1);
    ext_bit(b);
    check("R6", "underrun sticky", underrun_err, 1);
    rd_status();
    check("R8", "status read clears underrun", underrun_err, 0);
  endtask

  task automatic t_ext_chain();
    logic [7:0] v;
    logic b;
    do_reset(1'b1, 1'b0, 1'b0);
    wr(8'h3C);
    idle(2);
    ext_bit(b);
    v[0] = b;
    wr(8'hC3);
    for (int i = 1; i < 8; i++) begin
      ext_bit(b);
      v[i] = b;
    end
    check("R5", "first chained byte", v, 8'h3C);
    ext_byte(v);
    check("R5", "second chained byte", v, 8'hC3);
    check("R6", "refilled buffer avoids underrun", underrun_err, 0);
    ext_bit(b);
    check("R6", "underrun after last word", underrun_err, 1);
  endtask

  task automatic t_int_burst();
    int base, irq0, gmin, gmax;
    do_reset(1'b1, 1'b0, 1'b1);
    base = cap_n; irq0 = irq_n;
    wr(8'h5A);
    idle(1);
    wr(8'h96);
    idle(100);
    check("R4", "bits clocked", cap_n - base, 16);
    check("R3", "first byte", cap_byte(base), 8'h5A);
    check("R3", "second byte", cap_byte(base + 8), 8'h96);
    gmin = 1000; gmax = 0;
    for (int i = base + 1; i < base + 16; i++) begin
      if (cap_t[i] - cap_t[i-1] < gmin) gmin = cap_t[i] - cap_t[i-1];
      if (cap_t[i] - cap_t[i-1] > gmax) gmax = cap_t[i] - cap_t[i-1];
    end
    check("R4", "min clock period", gmin, 4);
    check("R4", "max clock period", gmax, 4);
    check("R4", "clock idles high", sclk_out, 1);
    check("R2", "irq per transfer", irq_n - irq0, 2);
    check("R7", "no underrun internal", underrun_err, 0);
  endtask

  task automatic t_fifo_refill();
    logic [7:0] v;
    logic b;
    int irq0;
    do_reset(1'b1, 1'b1, 1'b0);
    irq0 = irq_n;
    wr(8'h11); wr(8'h22); wr(8'h33);
    idle(3);
    check("R9", "hold loaded from queue", hold_empty, 0);
    ext_byte(v);
    check("R9", "queue byte 1", v, 8'h11);
    check("R9", "hold refilled same edge", hold_empty, 0);
    check("R9", "no irq while refilled", irq_n - irq0, 0);
    ext_byte(v);
    check("R9", "queue byte 2", v, 8'h22);
    ext_byte(v);
    check("R9", "queue byte 3", v, 8'h33);
    check("R9", "irq once when drained", irq_n - irq0, 1);
    check("R9", "hold empty when drained", hold_empty, 1);
    ext_bit(b);
    check("R7", "no underrun in queue mode", underrun_err, 0);
  endtask

  task automatic t_fifo_full();
    logic [7:0] v;
    logic [7:0] exp_w [5] = '{8'h01, 8'h82, 8'h43, 8'hC4, 8'h25};
    do_reset(1'b1, 1'b1, 1'b0);
    for (int i = 0; i < 5; i++) wr(exp_w[i]);
    check("R10", "no overflow at capacity", fifo_ovf, 0);
    wr(8'h66);
    idle(1);
    check("R10", "overflow on full write", fifo_ovf, 1);
    rd_status();
    check("R8", "status read clears overflow", fifo_ovf, 0);
    for (int k = 0; k < 5; k++) begin
      ext_byte(v);
      check("R10", "stored word order", v, exp_w[k]);
    end
    ext_byte(v);
    check("R10", "dropped word never sent", v, 8'hFF);
    check("R10", "queue drained", hold_empty, 1);
  endtask

  task automatic t_single();
    int base, irq0;
    do_reset(1'b0, 1'b0, 1'b1);
    base = cap_n; irq0 = irq_n;
    wr(8'hC5);
    wr(8'h3A);
    idle(60);
    check("R11", "only first write sent", cap_n - base, 8);
    check("R11", "direct byte", cap_byte(base), 8'hC5);
    check("R11", "irq at frame end", irq_n - irq0, 1);
    wr(8'h3A);
    idle(60);
    check("R11", "write accepted when idle", cap_n - base, 16);
    check("R11", "second direct byte", cap_byte(base + 8), 8'h3A);
    check("R11", "irq per frame", irq_n - irq0, 2);
    check("R7", "no underrun internal direct", underrun_err, 0);
  endtask

  initial begin
    rst_n = 1'b0; wr_en = 1'b0; wr_data = '0; stat_rd = 1'b0; ext_sclk = 1'b1;
    dbuf_en = 1'b1; fifo_en = 1'b0; int_clk = 1'b1;
    t_reset();
    t_dbuf_ext();
    t_ext_chain();
    t_int_burst();
    t_fifo_refill();
    t_fifo_full();
    t_single();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end
endmodule